// File: doc/BRIEF.md
# Single-to-Extended Floating-Point Widener

This block takes a 32-bit IEEE single-precision word and produces the equivalent 80-bit extended-precision register image. It is the conversion step used when a value is pushed onto a floating-point register stack. The result keeps the sign and carries a 15-bit exponent biased by 16383. Unlike the source format, it stores the integer bit of the significand explicitly. Every finite single value, denormals included, becomes an exactly equal extended value, so no rounding is ever needed.

Each accepted input also produces a 2-bit class tag of the kind a register stack keeps beside each entry. A small two-state controller tracks whether a result is being presented. It has two states:

- `W_IDLE`: nothing is presented.
- `W_SHOW`: a result is presented for exactly one cycle.

Each cycle, the transition `W_IDLE`/`W_SHOW` → `W_SHOW` is taken when `in_valid` is high. Otherwise the controller returns to `W_IDLE`. Reset forces `W_IDLE`.

Top module: `float_widen`

## Requirements
- R1: A word presented with `in_valid` high at a rising clock edge appears on `out_word`/`out_tag` with `out_valid` high after that edge. `out_valid` stays high for exactly one cycle per strobe, and back-to-back strobes give back-to-back results.
- R2: While `rst` (synchronous, active high) is asserted, the next edge gives `out_valid` = 0, `out_word` = 0 and `out_tag` = 2'b11, the empty code.
- R3: For a normal input (exponent field 1..254) the output is built as follows. Bit 79 is the input sign (bit 31). Bits 78..64 are the input exponent plus 16256. Bit 63 is 1. Bits 62..40 are the input fraction (bits 22..0), and bits 39..0 are 0. The tag is 2'b00.
- R4: An input with exponent 0 and fraction 0 gives bit 79 equal to the input sign with all other bits 0, and tag 2'b01.
- R5: An input with exponent 0 and a nonzero fraction is a denormal. Let p be the index of the fraction's highest set bit. The significand in bits 63..0 is the fraction shifted left by 63−p, so bit 63 is 1. Bits 78..64 hold 16234+p, the sign is kept, and the tag is 2'b00.
- R6: An input with exponent 255 and fraction 0 gives the sign, bits 78..64 = 7FFFh, bit 63 = 1 and bits 62..0 = 0. The tag is 2'b10.
- R7: An input with exponent 255 and a nonzero fraction is a NaN. It gives the sign, bits 78..64 = 7FFFh, and bits 63 and 62 both 1. Bits 61..40 hold the input fraction bits 21..0, and bits 39..0 are 0. The tag is 2'b10.
- R8: While `in_valid` is low, `out_word` and `out_tag` keep their last values. `out_tag` is never 2'b11 while `out_valid` is high.
- R9: When `rst` and `in_valid` are both high at the same edge, the reset wins. The outputs match R2, and no result is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: `in_word` holds a value to convert |
| in_word | input | 32 | Single-precision source word |
| out_valid | output | 1 | High for one cycle when a result is presented |
| out_word | output | 80 | Extended-precision result |
| out_tag | output | 2 | Class tag: 00 number, 01 zero, 10 NaN/infinity, 11 empty |

## Verification
Two functions can fall in the same cycle: capturing a new strobe and presenting the previous result. The bench provokes this with unbroken runs of strobes, and checks that each cycle's output belongs to the word strobed one edge earlier and never to the word now entering. Reset and a strobe can also meet at the same edge. The bench raises both together and checks that the next cycle shows the empty, not-valid state instead of the converted word. Random words are biased toward every input class and are checked against an independent bench model.

// File: rtl/sxw_pkg.sv
package sxw_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_DENORM,
        CLS_NORMAL,
        CLS_INF,
        CLS_NAN
    } src_class_e;

    typedef enum logic [1:0] {
        TAG_NUM     = 2'b00,
        TAG_ZERO    = 2'b01,
        TAG_SPECIAL = 2'b10,
        TAG_EMPTY   = 2'b11
    } reg_tag_e;

    typedef enum logic {
        W_IDLE,
        W_SHOW
    } wstate_e;

endpackage

// File: rtl/sxw_classify.sv
module sxw_classify
    import sxw_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W-1:0]  exp_in,
    input  logic [FRAC_W-1:0] frac_in,
    output src_class_e        cls
);
    logic exp_zero;
    logic exp_ones;
    logic frac_zero;

    assign exp_zero  = (exp_in == '0);
    assign exp_ones  = (&exp_in);
    assign frac_zero = (frac_in == '0);

    always_comb begin
        unique case ({exp_zero, exp_ones})
            2'b10:   cls = frac_zero ? CLS_ZERO : CLS_DENORM;
            2'b01:   cls = frac_zero ? CLS_INF  : CLS_NAN;
            default: cls = CLS_NORMAL;
        endcase
    end

endmodule

// File: rtl/sxw_lzc.sv
module sxw_lzc #(
    parameter int W  = 64,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] zeros
);
    // clear_above[i]: every bit strictly above i is zero
    logic [W-1:0] clear_above;
    logic [W-1:0] lead_zero;

    generate
        for (genvar i = W - 1; i >= 0; i--) begin : g_chain
            if (i == W - 1) begin : g_top
                assign clear_above[i] = 1'b1;
            end else begin : g_rest
                assign clear_above[i] = clear_above[i+1] & ~vec[i+1];
            end
            assign lead_zero[i] = clear_above[i] & ~vec[i];
        end
    endgenerate

    always_comb begin
        zeros = '0;
        for (int k = 0; k < W; k++) begin
            zeros = zeros + CW'(lead_zero[k]);
        end
    end

endmodule

// File: rtl/sxw_pack.sv
module sxw_pack
    import sxw_pkg::*;
#(
    parameter int SRC_EXP_W  = 8,
    parameter int SRC_FRAC_W = 23,
    parameter int DST_EXP_W  = 15,
    parameter int DST_MANT_W = 64,
    localparam int DST_W     = 1 + DST_EXP_W + DST_MANT_W
) (
    input  logic                  sign_in,
    input  logic [SRC_EXP_W-1:0]  exp_in,
    input  logic [SRC_FRAC_W-1:0] frac_in,
    input  src_class_e            cls,
    output logic [DST_W-1:0]      word_out,
    output reg_tag_e              tag_out
);
    localparam int SRC_BIAS = (1 << (SRC_EXP_W - 1)) - 1;
    localparam int DST_BIAS = (1 << (DST_EXP_W - 1)) - 1;
    localparam int NORM_OFF = DST_BIAS - SRC_BIAS;
    localparam int DEN_BASE = DST_BIAS - SRC_BIAS + 1;
    localparam int PAD_W    = DST_MANT_W - 1 - SRC_FRAC_W;
    localparam int LZ_W     = $clog2(DST_MANT_W + 1);

    logic [DST_MANT_W-1:0] den_raw;
    logic [LZ_W-1:0]       den_lz;
    logic [DST_MANT_W-1:0] mant;
    logic [DST_EXP_W-1:0]  expo;

    assign den_raw = {1'b0, frac_in, {PAD_W{1'b0}}};

    sxw_lzc #(.W(DST_MANT_W), .CW(LZ_W)) u_lzc (
        .vec   (den_raw),
        .zeros (den_lz)
    );

    always_comb begin
        mant    = '0;
        expo    = '0;
        tag_out = TAG_NUM;
        unique case (cls)
            CLS_ZERO: begin
                tag_out = TAG_ZERO;
            end
            CLS_DENORM: begin
                mant = den_raw << den_lz;
                expo = DST_EXP_W'(DEN_BASE - int'(den_lz));
            end
            CLS_NORMAL: begin
                mant = {1'b1, frac_in, {PAD_W{1'b0}}};
                expo = DST_EXP_W'(exp_in) + DST_EXP_W'(NORM_OFF);
            end
            CLS_INF: begin
                mant    = {1'b1, {(DST_MANT_W-1){1'b0}}};
                expo    = '1;
                tag_out = TAG_SPECIAL;
            end
            default: begin
                mant    = {2'b11, frac_in[SRC_FRAC_W-2:0], {PAD_W{1'b0}}};
                expo    = '1;
                tag_out = TAG_SPECIAL;
            end
        endcase
    end

    assign word_out = {sign_in, expo, mant};

endmodule

// File: rtl/float_widen.sv
module float_widen
    import sxw_pkg::*;
#(
    parameter int SRC_EXP_W  = 8,
    parameter int SRC_FRAC_W = 23,
    parameter int DST_EXP_W  = 15,
    parameter int DST_MANT_W = 64,
    localparam int SRC_W     = 1 + SRC_EXP_W + SRC_FRAC_W,
    localparam int DST_W     = 1 + DST_EXP_W + DST_MANT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [SRC_W-1:0] in_word,
    output logic             out_valid,
    output logic [DST_W-1:0] out_word,
    output logic [1:0]       out_tag
);
    localparam int SGN_BIT = DST_W - 1;
    localparam int INT_BIT = DST_MANT_W - 1;

    src_class_e         cls;
    logic [DST_W-1:0]   conv_word;
    reg_tag_e           conv_tag;
    wstate_e            state_q;
    wstate_e            state_d;
    logic [DST_W-1:0]   word_q;
    reg_tag_e           tag_q;

    sxw_classify #(.EXP_W(SRC_EXP_W), .FRAC_W(SRC_FRAC_W)) u_cls (
        .exp_in  (in_word[SRC_W-2 -: SRC_EXP_W]),
        .frac_in (in_word[SRC_FRAC_W-1:0]),
        .cls     (cls)
    );

    sxw_pack #(
        .SRC_EXP_W  (SRC_EXP_W),
        .SRC_FRAC_W (SRC_FRAC_W),
        .DST_EXP_W  (DST_EXP_W),
        .DST_MANT_W (DST_MANT_W)
    ) u_pack (
        .sign_in  (in_word[SRC_W-1]),
        .exp_in   (in_word[SRC_W-2 -: SRC_EXP_W]),
        .frac_in  (in_word[SRC_FRAC_W-1:0]),
        .cls      (cls),
        .word_out (conv_word),
        .tag_out  (conv_tag)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= W_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            W_IDLE:  state_d = in_valid ? W_SHOW : W_IDLE;
            W_SHOW:  state_d = in_valid ? W_SHOW : W_IDLE;
            default: state_d = W_IDLE;
        endcase
    end

    // output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            tag_q  <= TAG_EMPTY;
        end else if (in_valid) begin
            word_q <= conv_word;
            tag_q  <= conv_tag;
        end
    end

    assign out_valid = (state_q == W_SHOW);
    assign out_word  = word_q;
    assign out_tag   = tag_q;

    // R1: one result per strobe, one cycle later
    assert_valid_next_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_drop_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R8: outputs held without a strobe; empty tag never presented
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_word) && $stable(out_tag)));
    assert_no_empty_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_tag != 2'b11));
    // R6/R7: special tag carries an all-ones exponent and the integer bit
    assert_special_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_tag == 2'b10) |->
            ((&out_word[SGN_BIT-1 -: DST_EXP_W]) && out_word[INT_BIT]));
    // R3/R5: number tag always has the explicit integer bit set
    assert_int_bit_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_tag == 2'b00) |-> out_word[INT_BIT]);
    // R4: zero tag leaves only the sign
    assert_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_tag == 2'b01) |-> (out_word[SGN_BIT-1:0] == '0));
    // R9: a strobe during reset produces nothing
    assert_reset_wins_R9: assert property (@(posedge clk)
        rst |=> (!out_valid && out_tag == 2'b11));

endmodule

// File: tb/float_widen_test.sv
module float_widen_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic [79:0] out_word;
    logic [1:0]  out_tag;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    logic        mv;
    logic [79:0] mw;
    logic [1:0]  mt;
    string       mreq;
    bit          have_exp = 0;

    float_widen uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_tag   (out_tag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [81:0] model(input logic [31:0] w);
        logic        s = w[31];
        logic [7:0]  e = w[30:23];
        logic [22:0] f = w[22:0];
        logic [63:0] m;
        int          p;
        if (e == 0 && f == 0) return {2'b01, s, 79'b0};
        if (e == 0) begin
            p = 0;
            for (int i = 0; i < 23; i++) if (f[i]) p = i;
            m = 64'(f) << (63 - p);
            return {2'b00, s, 15'(16234 + p), m};
        end
        if (e == 8'hFF && f == 0) return {2'b10, s, 15'h7FFF, 1'b1, 63'b0};
        if (e == 8'hFF) return {2'b10, s, 15'h7FFF, 2'b11, f[21:0], 40'b0};
        return {2'b00, s, 15'(int'(e) + 16256), 1'b1, f, 40'b0};
    endfunction

    function automatic string req_of(input logic [31:0] w);
        if (w[30:23] == 0) return (w[22:0] == 0) ? "R4" : "R5";
        if (w[30:23] == 8'hFF) return (w[22:0] == 0) ? "R6" : "R7";
        return "R3";
    endfunction

    task automatic compare();
        string vreq;
        vreq = (mreq == "R2" || mreq == "R9" || mreq == "R8") ? mreq : "R1";
        tests++;
        if (out_valid !== mv) begin
            fails++;
            $display("FAIL %s valid: got %0b expected %0b", vreq, out_valid, mv);
        end
        tests++;
        if (out_word !== mw) begin
            fails++;
            $display("FAIL %s word: got %h expected %h", mreq, out_word, mw);
        end
        tests++;
        if (out_tag !== mt) begin
            fails++;
            $display("FAIL %s tag: got %b expected %b", mreq, out_tag, mt);
        end
    endtask

    task automatic step(input logic r, input logic v, input logic [31:0] w,
                        input string rlabel);
        @(negedge clk);
        if (have_exp) compare();
        rst = r; in_valid = v; in_word = w;
        have_exp = 1;
        if (r) begin
            mv = 0; mw = '0; mt = 2'b11; mreq = rlabel;
        end else if (v) begin
            {mt, mw} = model(w); mv = 1; mreq = req_of(w);
        end else begin
            mv = 0; mreq = "R8";
        end
    endtask

    function automatic logic [31:0] rand_word();
        logic [31:0] r = $urandom;
        case ($urandom % 6)
            0: return {r[31], 8'h00, 23'h0};
            1: return {r[31], 8'h00, 23'(r[22:0] >> ($urandom % 23))};
            2: return {r[31], 8'hFF, 23'h0};
            3: return {r[31], 8'hFF, r[22:1], 1'b1};
            4: return {r[31], 8'((r[30:23] % 254) + 1), r[22:0]};
            default: return r;
        endcase
    endfunction

    initial begin
        logic [31:0] corners [12];
        void'($urandom(32'h00C0FFEE));
        corners = '{32'h00000000, 32'h80000000, 32'h00000001, 32'h807FFFFF,
                    32'h00400000, 32'h00800000, 32'h7F7FFFFF, 32'h7F800000,
                    32'hFF800000, 32'h7FC00001, 32'h7F800001, 32'h3F800000};
        // R2: reset state
        for (int i = 0; i < 3; i++) step(1, 0, '0, "R2");
        // directed corners with gaps (R8 hold between)
        foreach (corners[i]) begin
            step(0, 1, corners[i], "");
            step(0, 0, 32'hDEADBEEF, "");
        end
        // back-to-back directed stream (R1)
        foreach (corners[i]) step(0, 1, corners[i], "");
        // R9: reset and strobe at the same edge
        step(1, 1, 32'h3F800000, "R9");
        step(0, 0, '0, "");
        step(0, 1, 32'h40490FDB, "");
        step(1, 1, 32'h7F800000, "R9");
        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic v = ($urandom % 4) != 0;
            step(0, v, v ? rand_word() : $urandom, "");
        end
        step(0, 0, '0, "");
        @(negedge clk);
        compare();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule